// File: doc/BRIEF.md
# PCIe fundamental reset sequencer

This block drives the active-low fundamental reset line of a PCI Express add-in card. It watches a power-good input and a reference-clock-stable input, and it holds the card in reset until two separate settling intervals have passed. The first interval runs from the point where power is reported good. The second runs from the point where the reference clock is reported stable. Only then does it release the line. A software reset request taken while the link is running puts the card back into reset for at least a guaranteed minimum width.

If power or the clock is lost, the reset line is pulled low at once, through a gate that has no register in its path. The sequence then starts again from the beginning. Every interval is given in nanoseconds and turned into a cycle count of the local clock, whose frequency is a parameter. Each count is rounded up, so no minimum is ever cut short. All pins are plain level signals; there is no data stream and no handshake.

Top module: `perst_sequencer`

## Requirements
- R1: While `rst` is sampled high on a rising edge, the sequencer returns to its hold state after that edge, so `perst_n` and `link_ready` are 0. The power, clock and pulse timers restart. If both inputs are high from the first edge after `rst` falls, `perst_n` rises on the (NP+3)th rising edge counted from that edge.
- R2: Suppose `refclk_stable` has been high long enough, and `pwr_good` and `refclk_stable` are first sampled high together on edge 0. Then `perst_n` stays 0 through edge NP+1 and goes to 1 after edge NP+2. NP is the power interval in cycles.
- R3: Suppose `pwr_good` has been high for at least NP cycles and `refclk_stable` is first sampled high on edge 0, with NC ≥ 2. Then `perst_n` stays 0 through edge NC and goes to 1 after edge NC+1. NC is the clock interval in cycles.
- R4: Each interval count is ceil(interval_ns × CLK_HZ / 1e9), with a minimum of 1. With CLK_HZ = 50 MHz, the intervals 1990 ns, 590 ns and 390 ns give NP = 100, NC = 30 and NW = 20.
- R5: When `pwr_good` goes low, `perst_n` and `link_ready` go to 0 in the same time step, with no clock edge needed.
- R6: When `refclk_stable` goes low, `perst_n` and `link_ready` go to 0 in the same time step, with no clock edge needed.
- R7: After power or the clock has been lost, the interval for that input restarts in full once the input returns. After a power loss, release again follows the timing of R2.
- R8: A `sw_reset_req` sampled high in the running state on edge 0 drives `perst_n` to 0 after edge 0. If the request is sampled low from edge 1 onward, `perst_n` stays 0 through edge NW and returns to 1 after edge NW+1.
- R9: A request still sampled high past the minimum width holds `perst_n` at 0. Release comes after the first edge that samples the request low.
- R10: `link_ready` is 1 exactly when `perst_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local timing clock, frequency CLK_HZ |
| rst | input | 1 | Synchronous active-high system reset |
| pwr_good | input | 1 | Card power is within its valid range |
| refclk_stable | input | 1 | Reference clock to the card is running and stable |
| sw_reset_req | input | 1 | Software request for a fundamental reset |
| perst_n | output | 1 | Active-low fundamental reset to the card |
| link_ready | output | 1 | High only while the card is out of reset |

## Verification
The bench measures each release on the exact edge, using interval values that are not whole multiples of the clock period. A design that rounded down, or that started a timer one cycle late, would release a cycle early or a cycle late and miss the check. Power and clock are each removed while the link runs, and the line is sampled before any clock edge. A registered drop, or a timer that kept its old count and skipped the full wait, would show up there. Software requests are tested as a one-cycle pulse, which must still last the minimum width, and as a long hold, which must last until the request is withdrawn.

// File: rtl/perst_pkg.sv
package perst_pkg;

  typedef enum logic [2:0] {
    ST_HOLD,
    ST_WAIT_PWR,
    ST_WAIT_CLK,
    ST_PULSE,
    ST_RUN
  } seq_state_t;

  // Cycles needed to cover ns at hz, rounded up, never below one.
  function automatic longint ns_to_cycles(longint ns, longint hz);
    longint c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int unsigned CYCLES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic done
);
  localparam int unsigned W = $clog2(CYCLES + 1);
  localparam logic [W-1:0] LIMIT = W'(CYCLES);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIMIT);

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIMIT);

  assert_clear_restart_R7: assert property (@(posedge clk) disable iff (rst)
    clear |=> !done);

endmodule

// File: rtl/perst_fsm.sv
module perst_fsm
  import perst_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_good,
  input  logic       refclk_stable,
  input  logic       sw_req,
  input  logic       pwr_done,
  input  logic       clk_done,
  input  logic       pulse_done,
  output seq_state_t state_q
);
  seq_state_t state_d;
  logic       supplies_ok;

  assign supplies_ok = pwr_good && refclk_stable;

  always_comb begin
    state_d = state_q;
    if (!supplies_ok) begin
      state_d = ST_HOLD;
    end else begin
      unique case (state_q)
        ST_HOLD:     state_d = ST_WAIT_PWR;
        ST_WAIT_PWR: if (pwr_done) state_d = ST_WAIT_CLK;
        ST_WAIT_CLK: if (clk_done) state_d = ST_PULSE;
        ST_PULSE:    if (pulse_done && !sw_req) state_d = ST_RUN;
        ST_RUN:      if (sw_req) state_d = ST_PULSE;
        default:     state_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_HOLD;
    else     state_q <= state_d;
  end

  assert_sysreset_R1: assert property (@(posedge clk)
    rst |=> (state_q == ST_HOLD));

  assert_release_pwr_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(state_q == ST_RUN) |-> pwr_done);

  assert_release_clk_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(state_q == ST_RUN) |-> clk_done);

  assert_release_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(state_q == ST_RUN) |-> pulse_done);

  assert_pwrfail_R5: assert property (@(posedge clk) disable iff (rst)
    !pwr_good |=> (state_q == ST_HOLD));

  assert_clkfail_R6: assert property (@(posedge clk) disable iff (rst)
    !refclk_stable |=> (state_q == ST_HOLD));

  assert_req_enter_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && sw_req && supplies_ok) |=> (state_q == ST_PULSE));

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PULSE && sw_req) |=> (state_q != ST_RUN));

endmodule

// File: rtl/perst_sequencer.sv
module perst_sequencer
  import perst_pkg::*;
#(
  parameter int unsigned CLK_HZ           = 100_000_000,
  parameter int unsigned PWR_SETTLE_NS    = 100_000_000,
  parameter int unsigned REFCLK_SETTLE_NS = 100_000,
  parameter int unsigned MIN_ASSERT_NS    = 100_000
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_good,
  input  logic refclk_stable,
  input  logic sw_reset_req,
  output logic perst_n,
  output logic link_ready
);
  localparam int unsigned PWR_CYC   = 32'(ns_to_cycles(longint'(PWR_SETTLE_NS), longint'(CLK_HZ)));
  localparam int unsigned CLK_CYC   = 32'(ns_to_cycles(longint'(REFCLK_SETTLE_NS), longint'(CLK_HZ)));
  localparam int unsigned PULSE_CYC = 32'(ns_to_cycles(longint'(MIN_ASSERT_NS), longint'(CLK_HZ)));

  seq_state_t state_q;
  logic       pwr_done, clk_done, pulse_done;
  logic       running;

  assign running = (state_q == ST_RUN);

  settle_timer #(.CYCLES(PWR_CYC)) u_pwr_timer (
    .clk(clk), .rst(rst), .clear(!pwr_good), .done(pwr_done)
  );

  settle_timer #(.CYCLES(CLK_CYC)) u_clk_timer (
    .clk(clk), .rst(rst), .clear(!refclk_stable), .done(clk_done)
  );

  settle_timer #(.CYCLES(PULSE_CYC)) u_pulse_timer (
    .clk(clk), .rst(rst), .clear(running), .done(pulse_done)
  );

  perst_fsm u_fsm (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .refclk_stable(refclk_stable),
    .sw_req(sw_reset_req), .pwr_done(pwr_done), .clk_done(clk_done),
    .pulse_done(pulse_done), .state_q(state_q)
  );

  // Loss of either input drops the line without waiting for an edge.
  assign perst_n    = running && pwr_good && refclk_stable;
  assign link_ready = perst_n;

  assert_fail_gate_R5: assert property (@(negedge clk) disable iff (rst)
    !pwr_good |-> !perst_n);

endmodule

// File: tb/sim_perst_sequencer.sv
`timescale 1ns/1ps
module sim_perst_sequencer;
  localparam int NP = 100;
  localparam int NC = 30;
  localparam int NW = 20;

  logic clk = 1'b0;
  logic rst, pwr_good, refclk_stable, sw_reset_req;
  logic perst_n, link_ready;
  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 0;

  always #10 clk = ~clk;

  perst_sequencer #(
    .CLK_HZ(50_000_000), .PWR_SETTLE_NS(1990),
    .REFCLK_SETTLE_NS(590), .MIN_ASSERT_NS(390)
  ) u0 (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .refclk_stable(refclk_stable),
    .sw_reset_req(sw_reset_req), .perst_n(perst_n), .link_ready(link_ready)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_line(input string req, input logic exp);
    check(req, perst_n, exp);
    check({req, " link_ready"}, link_ready, exp);
  endtask

  // From a negedge, move to the negedge after the k-th following edge (k=0 is next).
  task automatic after_edge(input int k);
    repeat (k + 1) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1; pwr_good = 0; refclk_stable = 0; sw_reset_req = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_line("R1 reset state", 1'b0);
    rst = 0;
  endtask

  task automatic t_powerup();
    pwr_good = 1; refclk_stable = 1;
    after_edge(NP + 1);
    check_line("R2 R4 held through edge NP+1", 1'b0);
    after_edge(0);
    check_line("R2 R4 released after edge NP+2", 1'b1);
    check("R10 link_ready follows perst_n", link_ready, perst_n);
  endtask

  task automatic t_sw_short();
    sw_reset_req = 1;
    after_edge(0);
    check_line("R8 request asserts", 1'b0);
    sw_reset_req = 0;
    after_edge(NW - 1);
    check_line("R8 held through edge NW", 1'b0);
    after_edge(0);
    check_line("R8 released after edge NW+1", 1'b1);
  endtask

  task automatic t_sw_long();
    sw_reset_req = 1;
    after_edge(25);
    check_line("R9 held past minimum while requested", 1'b0);
    after_edge(13);
    check_line("R9 held at edge 39", 1'b0);
    sw_reset_req = 0;
    after_edge(0);
    check_line("R9 released after withdrawal", 1'b1);
  endtask

  task automatic t_pwr_fail();
    pwr_good = 0;
    #1;
    check_line("R5 immediate drop on power loss", 1'b0);
    @(negedge clk);
    after_edge(2);
    pwr_good = 1;
    after_edge(NP + 1);
    check_line("R7 power interval restarted", 1'b0);
    after_edge(0);
    check_line("R7 released after full power interval", 1'b1);
  endtask

  task automatic t_clk_fail_late();
    refclk_stable = 0;
    #1;
    check_line("R6 immediate drop on clock loss", 1'b0);
    @(negedge clk);
    after_edge(3);
    refclk_stable = 1;
    after_edge(NC);
    check_line("R3 held through edge NC", 1'b0);
    after_edge(0);
    check_line("R3 released after edge NC+1", 1'b1);
  endtask

  task automatic t_sysreset_run();
    rst = 1;
    after_edge(0);
    check_line("R1 reset from running", 1'b0);
    rst = 0;
    after_edge(NP + 1);
    check_line("R1 timers restarted after reset", 1'b0);
    after_edge(0);
    check_line("R1 released after full interval", 1'b1);
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_sw_short();
    t_sw_long();
    t_pwr_fail();
    t_clk_fail_late();
    t_sysreset_run();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule